// File: doc/BRIEF.md
# Wakeup Event Controller

This block collects wakeup sources from across a chip, detects a programmable edge on each, and latches what it sees so that a power sequencer can tell why the system woke. It drives a single wake request towards that sequencer. The sources come in three groups. Pin sources are direct pin transitions, each with its own edge polarity. Interrupt sources are peripheral interrupt lines, also with their own polarity. Port sources are a bank of general-purpose port pins. The port bank has no polarity control. Any enabled, latched port event is folded into one aggregate bit of the interrupt group.

Software reaches the block through a simple word-addressed register port with a valid strobe and a write flag. Through it software programs the enables and polarities, reads the latched raw status of each group, and clears pending bits by writing ones. A latched bit only counts towards the wake request when its enable is set. The raw status always shows what was detected, so software can poll sources it has not armed. Inputs are assumed to be synchronous to the block clock already.

Top module: `wake_event_ctrl`

## Requirements
- R1: After reset every enable word reads 0, the pin polarity word reads 0 (falling edge), the interrupt polarity word reads its reset mask (default 0x0000_2600: bits 9, 10 and 13 rising, all others falling), every raw status word reads 0 and `wake_req` is low.
- R2: Word addresses are: 0 pin enable, 1 pin polarity, 2 pin raw, 3 interrupt enable, 4 interrupt polarity, 5 interrupt raw, 6 port enable, 7 port raw, 8 port polarity slot. A read request (`req_valid`=1, `req_write`=0) returns the addressed word on `rd_data` after the next rising clock edge. Enable and polarity words read back the value last written.
- R3: For pin and interrupt sources, a polarity bit of 1 latches a change from 0 to 1, and a bit of 0 latches a change from 1 to 0. A change in the other direction, or a steady level, latches nothing.
- R4: A detected edge sets its raw status bit whether or not that source is enabled, and the raw word reads it back.
- R5: Writing a raw status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A raw bit never clears without such a write.
- R6: If an edge on a source is detected in the same cycle as a clearing write to that raw bit, the bit stays set.
- R7: `wake_req` is high exactly while some pin or interrupt raw bit is set and its enable bit is set. Latched bits that are not enabled do not raise it.
- R8: Port sources latch a 0-to-1 change into the port raw word. While any port raw bit is set with its port enable set, interrupt raw bit AGG_IDX (default 31) is set one cycle later. That bit wakes only if interrupt enable bit AGG_IDX is set. The `irq_in` line at AGG_IDX is ignored.
- R9: The port polarity slot (address 8) always reads 0, and writes to it change nothing. Port sources still latch only 0-to-1 changes after such a write. Other unmapped addresses read 0.
- R10: A source level that is present while reset is released latches nothing. Only changes seen after the first clock following reset release count.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_in | input | PIN_W | Pin transition sources |
| irq_in | input | IRQ_W | Peripheral interrupt sources |
| port_in | input | PORT_W | Port-pin sources feeding the aggregate event |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after a read request |
| wake_req | output | 1 | Wake request to the power sequencer |

## Verification
Every cycle, the assertions check three things in each group's latch. A raw bit clears only under a clearing write. A bit never appears without a detected edge or an aggregate set. An edge that coincides with a clear keeps its bit. The assertions also check that an enabled port event raises the aggregate interrupt bit on the next cycle, that the port polarity slot reads zero, and that no source latches while the block comes out of reset. The bench scenarios are needed to show several other behaviours. These are the choice between rising and falling edges across random polarities and levels, the gating of the wake request by enables, reset values, register readback, and the fact that the `irq_in` line under the aggregate bit and port polarity writes have no effect.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_PIN_EN   = 4'd0,
    A_PIN_POL  = 4'd1,
    A_PIN_RAW  = 4'd2,
    A_IRQ_EN   = 4'd3,
    A_IRQ_POL  = 4'd4,
    A_IRQ_RAW  = 4'd5,
    A_PORT_EN  = 4'd6,
    A_PORT_RAW = 4'd7,
    A_PORT_POL = 4'd8
  } wk_addr_e;
endpackage

// File: rtl/wk_cfg_reg.sv
module wk_cfg_reg #(
  parameter int unsigned   W   = 32,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST;
    else if (we) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/wk_edge_latch.sv
module wk_edge_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] lvl_set,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q, raw_q, raw_d, hit;
  logic         armed_q;

  // A hit is a change of level that lands on the selected polarity.
  always_comb begin
    hit   = armed_q ? ((src ^ prev_q) & ~(src ^ pol)) : '0;
    raw_d = (raw_q & ~clr) | hit | lvl_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
      raw_q   <= '0;
    end else begin
      prev_q  <= src;
      armed_q <= 1'b1;
      raw_q   <= raw_d;
    end
  end

  assign raw = raw_q;

  assert_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~raw_q) & ~$past(clr)) == '0));

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((raw_q & ~$past(raw_q)) & ~$past(hit | lvl_set)) == '0));

  assert_edge_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & clr)) |=> ((raw_q & $past(hit & clr)) == $past(hit & clr)));

  assert_quiet_at_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && lvl_set == '0) |=> (raw_q == '0));
endmodule

// File: rtl/wk_bus_if.sv
module wk_bus_if
  import wk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIN_W  = 32,
  parameter int unsigned IRQ_W  = 32,
  parameter int unsigned PORT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PIN_W-1:0]  pin_en,
  input  logic [PIN_W-1:0]  pin_pol,
  input  logic [PIN_W-1:0]  pin_raw,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic [IRQ_W-1:0]  irq_pol,
  input  logic [IRQ_W-1:0]  irq_raw,
  input  logic [PORT_W-1:0] port_en,
  input  logic [PORT_W-1:0] port_raw,
  output logic              we_pin_en,
  output logic              we_pin_pol,
  output logic              we_irq_en,
  output logic              we_irq_pol,
  output logic              we_port_en,
  output logic [PIN_W-1:0]  clr_pin,
  output logic [IRQ_W-1:0]  clr_irq,
  output logic [PORT_W-1:0] clr_port,
  output logic [DATA_W-1:0] rd_data
);
  logic              wr_go, rd_go;
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    wr_go      = req_valid & req_write;
    rd_go      = req_valid & ~req_write;
    we_pin_en  = wr_go && (req_addr == A_PIN_EN);
    we_pin_pol = wr_go && (req_addr == A_PIN_POL);
    we_irq_en  = wr_go && (req_addr == A_IRQ_EN);
    we_irq_pol = wr_go && (req_addr == A_IRQ_POL);
    we_port_en = wr_go && (req_addr == A_PORT_EN);
    clr_pin    = (wr_go && req_addr == A_PIN_RAW)  ? req_wdata[PIN_W-1:0]  : '0;
    clr_irq    = (wr_go && req_addr == A_IRQ_RAW)  ? req_wdata[IRQ_W-1:0]  : '0;
    clr_port   = (wr_go && req_addr == A_PORT_RAW) ? req_wdata[PORT_W-1:0] : '0;
  end

  always_comb begin
    rd_d = '0;
    case (req_addr)
      A_PIN_EN:   rd_d = DATA_W'(pin_en);
      A_PIN_POL:  rd_d = DATA_W'(pin_pol);
      A_PIN_RAW:  rd_d = DATA_W'(pin_raw);
      A_IRQ_EN:   rd_d = DATA_W'(irq_en);
      A_IRQ_POL:  rd_d = DATA_W'(irq_pol);
      A_IRQ_RAW:  rd_d = DATA_W'(irq_raw);
      A_PORT_EN:  rd_d = DATA_W'(port_en);
      A_PORT_RAW: rd_d = DATA_W'(port_raw);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_go) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  assert_port_pol_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && req_addr == A_PORT_POL) |=> (rd_data == '0));
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wk_pkg::*;
#(
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      PIN_W       = 32,
  parameter int unsigned      IRQ_W       = 32,
  parameter int unsigned      PORT_W      = 32,
  parameter int unsigned      AGG_IDX     = 31,
  parameter logic [IRQ_W-1:0] IRQ_POL_RST = 32'h0000_2600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic [IRQ_W-1:0]  irq_in,
  input  logic [PORT_W-1:0] port_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_req
);
  localparam logic [PORT_W-1:0] PORT_POL = '1;

  logic              rst_s1_q, rst_sync_q;
  logic [PIN_W-1:0]  pin_en, pin_pol, pin_raw, clr_pin;
  logic [IRQ_W-1:0]  irq_en, irq_pol, irq_raw, clr_irq, irq_src, irq_lvl;
  logic [PORT_W-1:0] port_en, port_raw, clr_port;
  logic              we_pin_en, we_pin_pol, we_irq_en, we_irq_pol, we_port_en;
  logic              agg_hit;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_q <= rst_s1_q;
    end
  end

  wk_bus_if #(.DATA_W(DATA_W), .PIN_W(PIN_W), .IRQ_W(IRQ_W), .PORT_W(PORT_W)) u_bus (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .pin_en(pin_en), .pin_pol(pin_pol), .pin_raw(pin_raw),
    .irq_en(irq_en), .irq_pol(irq_pol), .irq_raw(irq_raw),
    .port_en(port_en), .port_raw(port_raw),
    .we_pin_en(we_pin_en), .we_pin_pol(we_pin_pol), .we_irq_en(we_irq_en),
    .we_irq_pol(we_irq_pol), .we_port_en(we_port_en),
    .clr_pin(clr_pin), .clr_irq(clr_irq), .clr_port(clr_port),
    .rd_data(rd_data)
  );

  wk_cfg_reg #(.W(PIN_W), .RST('0)) u_pin_en (
    .clk(clk), .rst_n(rst_sync_q), .we(we_pin_en), .wdata(req_wdata[PIN_W-1:0]), .q(pin_en));
  wk_cfg_reg #(.W(PIN_W), .RST('0)) u_pin_pol (
    .clk(clk), .rst_n(rst_sync_q), .we(we_pin_pol), .wdata(req_wdata[PIN_W-1:0]), .q(pin_pol));
  wk_cfg_reg #(.W(IRQ_W), .RST('0)) u_irq_en (
    .clk(clk), .rst_n(rst_sync_q), .we(we_irq_en), .wdata(req_wdata[IRQ_W-1:0]), .q(irq_en));
  wk_cfg_reg #(.W(IRQ_W), .RST(IRQ_POL_RST)) u_irq_pol (
    .clk(clk), .rst_n(rst_sync_q), .we(we_irq_pol), .wdata(req_wdata[IRQ_W-1:0]), .q(irq_pol));
  wk_cfg_reg #(.W(PORT_W), .RST('0)) u_port_en (
    .clk(clk), .rst_n(rst_sync_q), .we(we_port_en), .wdata(req_wdata[PORT_W-1:0]), .q(port_en));

  // The aggregate slot ignores its own line and is set by enabled port events.
  always_comb begin
    agg_hit          = |(port_raw & port_en);
    irq_src          = irq_in;
    irq_src[AGG_IDX] = 1'b0;
    irq_lvl          = '0;
    irq_lvl[AGG_IDX] = agg_hit;
  end

  wk_edge_latch #(.W(PIN_W)) u_pin_grp (
    .clk(clk), .rst_n(rst_sync_q), .src(pin_in), .pol(pin_pol),
    .clr(clr_pin), .lvl_set('0), .raw(pin_raw));
  wk_edge_latch #(.W(IRQ_W)) u_irq_grp (
    .clk(clk), .rst_n(rst_sync_q), .src(irq_src), .pol(irq_pol),
    .clr(clr_irq), .lvl_set(irq_lvl), .raw(irq_raw));
  wk_edge_latch #(.W(PORT_W)) u_port_grp (
    .clk(clk), .rst_n(rst_sync_q), .src(port_in), .pol(PORT_POL),
    .clr(clr_port), .lvl_set('0), .raw(port_raw));

  assign wake_req = (|(pin_raw & pin_en)) | (|(irq_raw & irq_en));

  assert_agg_follows_port_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    agg_hit |=> irq_raw[AGG_IDX]);
endmodule

// File: tb/test_wake_event_ctrl.sv
module test_wake_event_ctrl;
  localparam int W = 32;
  localparam int AGG = 31;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  pin_in, irq_in, port_in;
  logic          req_valid, req_write;
  logic [3:0]    req_addr;
  logic [W-1:0]  req_wdata;
  logic [W-1:0]  rd_data;
  logic          wake_req;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wake_event_ctrl i_wake_event_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_in(irq_in), .port_in(port_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .wake_req(wake_req));

  function automatic logic exp_latch(input logic pol, input logic lv0, input logic lv1);
    return (lv0 != lv1) && (lv1 == pol);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    pin_in = '0; irq_in = '0; port_in = '0;
    irq_in[9] = 1'b1;            // R10: high level held through reset on a rising source
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset values
    chk("R1 wake", {31'd0, wake_req}, '0);
    rd(4'd0, v); chk("R1 pin_en", v, '0);
    rd(4'd1, v); chk("R1 pin_pol", v, '0);
    rd(4'd3, v); chk("R1 irq_en", v, '0);
    rd(4'd4, v); chk("R1 irq_pol", v, 32'h0000_2600);
    rd(4'd6, v); chk("R1 port_en", v, '0);
    rd(4'd2, v); chk("R1 pin_raw", v, '0);
    rd(4'd7, v); chk("R1 port_raw", v, '0);
    rd(4'd5, v); chk("R10 irq_raw no latch of reset level", v, '0);

    // R2 readback
    wr(4'd0, 32'hA5A5_0F0F); rd(4'd0, v); chk("R2 pin_en readback", v, 32'hA5A5_0F0F);
    wr(4'd4, 32'h1234_5678); rd(4'd4, v); chk("R2 irq_pol readback", v, 32'h1234_5678);
    wr(4'd0, '0); wr(4'd4, 32'h0000_2600);
    rd(4'd12, v); chk("R9 unmapped reads zero", v, '0);

    // R3 R4 R7 random edge/polarity/enable
    for (int it = 0; it < 40; it++) begin
      logic grp, pol, en, lv0, lv1, e;
      int idx;
      logic [3:0] a_en, a_pol, a_raw, a_oen;
      grp = 1'($urandom_range(1, 0));
      idx = grp ? $urandom_range(30, 0) : $urandom_range(31, 0);
      pol = 1'($urandom_range(1, 0)); en = 1'($urandom_range(1, 0));
      lv0 = 1'($urandom_range(1, 0)); lv1 = 1'($urandom_range(1, 0));
      a_en  = grp ? 4'd3 : 4'd0; a_pol = grp ? 4'd4 : 4'd1;
      a_raw = grp ? 4'd5 : 4'd2; a_oen = grp ? 4'd0 : 4'd3;
      wr(a_oen, '0);
      wr(a_en, en ? (32'd1 << idx) : '0);
      rd(a_pol, v); v[idx] = pol; wr(a_pol, v);
      @(negedge clk); if (grp) irq_in[idx] = lv0; else pin_in[idx] = lv0;
      idle(2);
      wr(4'd2, '1); wr(4'd5, '1);
      @(negedge clk); if (grp) irq_in[idx] = lv1; else pin_in[idx] = lv1;
      idle(2);
      e = exp_latch(pol, lv0, lv1);
      rd(a_raw, v);
      chk(grp ? "R3 R4 irq raw" : "R3 R4 pin raw", v, e ? (32'd1 << idx) : '0);
      chk("R7 wake gated by enable", {31'd0, wake_req}, {31'd0, e & en});
    end
    wr(4'd0, '0); wr(4'd3, '0);
    pin_in = '0; irq_in = '0; idle(2);
    wr(4'd2, '1); wr(4'd5, '1);

    // R5 partial clear; R7 disabled latched bit does not wake
    wr(4'd1, 32'h0000_0003);
    @(negedge clk); pin_in[1:0] = 2'b11; idle(2);
    chk("R7 latched but disabled", {31'd0, wake_req}, '0);
    wr(4'd0, 32'h1); chk("R7 enabled latched wakes", {31'd0, wake_req}, 32'd1);
    wr(4'd2, 32'h1); rd(4'd2, v); chk("R5 write-one clears only bit0", v, 32'h2);
    chk("R7 wake drops after clear", {31'd0, wake_req}, '0);

    // R6 edge in same cycle as clear
    @(negedge clk); pin_in[1] = 1'b0; idle(2);       // falling: no latch under rising
    @(negedge clk);
    pin_in[1] = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd2; req_wdata = 32'h2;
    @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
    rd(4'd2, v); chk("R6 edge beats clear", v, 32'h2);
    wr(4'd2, 32'h2); rd(4'd2, v); chk("R5 clear alone", v, '0);
    wr(4'd0, '0);

    // R8 port aggregation
    wr(4'd6, 32'h20);
    @(negedge clk); port_in[5] = 1'b1; idle(3);
    rd(4'd7, v); chk("R8 port raw latched", v, 32'h20);
    rd(4'd5, v); chk("R8 aggregate set", v, 32'h8000_0000);
    chk("R8 aggregate not enabled", {31'd0, wake_req}, '0);
    wr(4'd3, 32'h8000_0000); chk("R8 aggregate wakes", {31'd0, wake_req}, 32'd1);
    wr(4'd7, 32'h20); wr(4'd5, 32'h8000_0000);
    rd(4'd5, v); chk("R8 aggregate cleared", v, '0);
    chk("R8 wake low", {31'd0, wake_req}, '0);
    @(negedge clk); port_in[6] = 1'b1; idle(3);
    rd(4'd7, v); chk("R8 disabled port latches raw", v, 32'h40);
    rd(4'd5, v); chk("R8 disabled port no aggregate", v, '0);
    wr(4'd4, '1);
    @(negedge clk); irq_in[AGG] = 1'b1; idle(2);
    rd(4'd5, v); chk("R8 agg line ignored", v, '0);
    irq_in[AGG] = 1'b0;

    // R9 port polarity slot
    wr(4'd8, '1); rd(4'd8, v); chk("R9 port pol reads zero", v, '0);
    wr(4'd7, '1);
    @(negedge clk); port_in[6] = 1'b0; idle(2);
    rd(4'd7, v); chk("R9 port falling ignored", v, '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule